// File: doc/BRIEF.md
# Ramp ADC Conversion Controller

This block is the digital side of a counter-ramp analog-to-digital converter. It drives a code to an external DAC and steps that code one count at a time. A single comparator bit comes back from the analog side. It goes high once the DAC level has reached the input level. When that happens, the controller stores the code that caused the trip and pulses a done strobe. In the stopping mode it then starts a fresh ramp.

The ramp can run upward from zero or downward from full scale. A wrap option lets the counter cycle without stopping. In that mode each rising edge of the comparator only records a crossing point. A step-enable input sets the stepping rate, so the code can be held while the DAC settles. The comparator passes through a two-flop synchronizer. The controller keeps a matching two-stage copy of the code so that the stored result is the code the comparator actually judged.

If a ramp reaches the end of its range without a trip, the end code is stored and a range flag is raised. The flag is hit_top for an up-ramp and hit_bottom for a down-ramp.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: While rst_n is low, code is 0 when ramp_down is 0 and 255 when ramp_down is 1. conv_code, conv_done, hit_top and hit_bottom are all 0.
- R2: In up-ramp mode, each cycle with step_en high adds one to code, starting from 0.
- R3: conv_code receives the first code whose comparator sample reads high. conv_done is a pulse exactly one cycle wide.
- R4: In stopping mode with step_en held high, conv_done rises L+3 cycles after the ramp starts for an input level L. This accounts for the two synchronizer flops and the result register. At that same edge code returns to its start value, so a new conversion takes the same time again.
- R5: In down-ramp mode (ramp_down=1) code counts down from 255. A level L reads back as L after 255-L+3 cycles.
- R6: conv_code, hit_top and hit_bottom change only at the edge where conv_done rises. They hold their values through the following ramp.
- R7: While step_en is low, code holds its value. The only exception is the restart that follows a finished conversion.
- R8: An up-ramp that reaches 255 with no trip finishes after 258 cycles. It reports 255 with hit_top=1. A trip exactly at 255 reports 255 with hit_top=0.
- R9: A down-ramp that reaches 0 with no trip reports 0 with hit_bottom=1. A trip exactly at 0 reports 0 with hit_bottom=0.
- R10: With wrap_mode=1 the counter never stops. It wraps from 255 to 0 (or from 0 to 255 when counting down). Each rising edge of the comparator latches a result and pulses conv_done without restarting the ramp, and no range flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Advance the code on this cycle |
| ramp_down | input | 1 | 0: ramp up from 0, 1: ramp down from 255 |
| wrap_mode | input | 1 | 1: free-running ramp, crossings only recorded |
| reached | input | 1 | Asynchronous comparator output: test level has reached the input |
| code | output | 8 | Code driven to the DAC |
| conv_code | output | 8 | Latched conversion result |
| conv_done | output | 1 | One-cycle strobe when conv_code is updated |
| hit_top | output | 1 | Up-ramp ended at 255 without a trip |
| hit_bottom | output | 1 | Down-ramp ended at 0 without a trip |

## Verification
An end-of-range event and a comparator trip can fall in the same cycle when the input level equals the last code of the ramp. The bench provokes this with a level of 255 on an up-ramp and 0 on a down-ramp. It judges that the result is the end code with the range flag clear. It then contrasts this with levels just past the range, where the same finish cycle must raise the flag. A second coincidence is a conversion finishing while step_en is low. The slow-stepping scenario judges that the restart still happens and that the result is exact.

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en,
  input  logic         ramp_down,
  input  logic         wrap_mode,
  input  logic         reached,
  output logic [W-1:0] code,
  output logic [W-1:0] conv_code,
  output logic         conv_done,
  output logic         hit_top,
  output logic         hit_bottom
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt, code_d1, code_d2;
  logic         live1, live2;
  logic         sync1, sync2, sync3;

  wire [W-1:0] start_code = ramp_down ? TOP : '0;
  wire [W-1:0] end_code   = ramp_down ? '0 : TOP;
  wire         at_end     = (cnt == end_code);
  wire         crossing   = live2 & sync2 & (wrap_mode ? ~sync3 : 1'b1);
  wire         ran_out    = ~wrap_mode & live2 & ~sync2 & (code_d2 == end_code);
  wire         finish     = crossing | ran_out;
  wire         restart    = finish & ~wrap_mode;

  assign code = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= start_code;
      code_d1    <= '0;
      code_d2    <= '0;
      live1      <= 1'b0;
      live2      <= 1'b0;
      sync1      <= 1'b0;
      sync2      <= 1'b0;
      sync3      <= 1'b0;
      conv_code  <= '0;
      conv_done  <= 1'b0;
      hit_top    <= 1'b0;
      hit_bottom <= 1'b0;
    end else begin
      sync1     <= reached;
      sync2     <= sync1;
      sync3     <= sync2;
      code_d1   <= cnt;
      code_d2   <= code_d1;
      live1     <= ~restart;
      live2     <= live1 & ~restart;
      conv_done <= finish;
      if (finish) begin
        conv_code  <= code_d2;
        hit_top    <= ran_out & ~ramp_down;
        hit_bottom <= ran_out & ramp_down;
      end
      if (restart)
        cnt <= start_code;
      else if (step_en && (wrap_mode || !at_end))
        cnt <= ramp_down ? cnt - 1'b1 : cnt + 1'b1;
    end
  end

  // R2
  a_r2_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !restart && !at_end && !ramp_down && !wrap_mode)
      |=> code == W'($past(code) + 1'b1));

  // R3
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !conv_done);

  // R6
  a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |-> ($stable(conv_code) && $stable(hit_top) && $stable(hit_bottom)));

  // R7
  a_r7_hold_code: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !restart) |=> $stable(code));

  // R8
  a_r8_top_code: assert property (@(posedge clk) disable iff (!rst_n)
    hit_top |-> conv_code == TOP);

  // R9
  a_r9_bottom_code: assert property (@(posedge clk) disable iff (!rst_n)
    hit_bottom |-> conv_code == '0);

  // R10
  a_r10_wrap_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_mode && conv_done) |-> (!hit_top && !hit_bottom));
endmodule

// File: tb/ramp_adc_ctrl_test.sv
module ramp_adc_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_en = 1'b1;
  logic       ramp_down = 1'b0;
  logic       wrap_mode = 1'b0;
  logic       reached;
  logic [7:0] code, conv_code;
  logic       conv_done, hit_top, hit_bottom;
  int         lvl = 0;
  int         total = 0;
  int         fails = 0;

  always #4 clk = ~clk;

  assign reached = ramp_down ? (int'(code) <= lvl) : (int'(code) >= lvl);

  ramp_adc_ctrl #(.W(8)) uut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .ramp_down(ramp_down),
    .wrap_mode(wrap_mode), .reached(reached), .code(code),
    .conv_code(conv_code), .conv_done(conv_done), .hit_top(hit_top),
    .hit_bottom(hit_bottom)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start(input logic dn, input logic wr, input int level);
    @(negedge clk);
    rst_n = 1'b0; ramp_down = dn; wrap_mode = wr; step_en = 1'b1; lvl = level;
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset code", code, dn ? 255 : 0);
    chk("R1 reset outputs", {conv_done, hit_top, hit_bottom, conv_code}, 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_done(input int maxc, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!conv_done && n < maxc);
    if (!conv_done) n = -1;
  endtask

  task automatic t_up(input int level);
    int n;
    start(1'b0, 1'b0, level);
    @(negedge clk);
    chk("R2 first step", code, 1);
    @(negedge clk);
    chk("R2 second step", code, 2);
    wait_done(400, n);
    chk("R4 up conversion time", n + 2, level + 3);
    chk("R3 up result", conv_code, level);
    chk("R4 restart code", code, 0);
    @(negedge clk);
    chk("R3 done one cycle", conv_done, 0);
    chk("R6 result held", conv_code, level);
    wait_done(400, n);
    chk("R4 repeat conversion time", n + 1, level + 3);
  endtask

  task automatic t_down(input int level);
    int n;
    start(1'b1, 1'b0, level);
    wait_done(400, n);
    chk("R5 down conversion time", n, 255 - level + 3);
    chk("R5 down result", conv_code, level);
    chk("R5 down restart", code, 255);
  endtask

  task automatic t_slow();
    int n;
    start(1'b0, 1'b0, 20);
    step_en = 1'b0;
    repeat (10) @(negedge clk);
    chk("R7 code held", code, 0);
    chk("R7 no done while held", conv_done, 0);
    n = 0;
    while (!conv_done && n < 500) begin
      step_en = (n % 3 == 0);
      @(negedge clk);
      n++;
    end
    chk("R7 slow result", conv_code, 20);
    chk("R7 restart with step_en low", code, 0);
  endtask

  task automatic t_top();
    int n;
    start(1'b0, 1'b0, 300);
    wait_done(400, n);
    chk("R8 overflow time", n, 258);
    chk("R8 overflow result", conv_code, 255);
    chk("R8 overflow flag", hit_top, 1);
    lvl = 10;
    repeat (5) @(negedge clk);
    chk("R6 flag held", hit_top, 1);
    wait_done(400, n);
    chk("R6 flag cleared", hit_top, 0);
    chk("R6 new result", conv_code, 10);
    start(1'b0, 1'b0, 255);
    wait_done(400, n);
    chk("R8 trip at 255 result", conv_code, 255);
    chk("R8 trip at 255 no flag", hit_top, 0);
  endtask

  task automatic t_bottom();
    int n;
    start(1'b1, 1'b0, -1);
    wait_done(400, n);
    chk("R9 underflow time", n, 258);
    chk("R9 underflow result", conv_code, 0);
    chk("R9 underflow flag", hit_bottom, 1);
    start(1'b1, 1'b0, 0);
    wait_done(400, n);
    chk("R9 trip at 0 result", conv_code, 0);
    chk("R9 trip at 0 no flag", hit_bottom, 0);
  endtask

  task automatic t_wrap();
    int n;
    start(1'b0, 1'b1, 40);
    wait_done(400, n);
    chk("R10 first crossing time", n, 43);
    chk("R10 first crossing result", conv_code, 40);
    chk("R10 no restart", code, 43);
    wait_done(400, n);
    chk("R10 wrap period", n, 256);
    chk("R10 result after wrap", conv_code, 40);
    chk("R10 no flag", {hit_top, hit_bottom}, 0);
    start(1'b1, 1'b1, 200);
    wait_done(400, n);
    chk("R10 down crossing time", n, 58);
    chk("R10 down crossing result", conv_code, 200);
    wait_done(400, n);
    chk("R10 down wrap period", n, 256);
  endtask

  initial begin
    t_up(0);
    t_up(5);
    t_up(100);
    t_up(200);
    t_down(250);
    t_down(10);
    t_slow();
    t_top();
    t_bottom();
    t_wrap();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule